// File: doc/BRIEF.md
# Single-Clock FIFO Controller with Selectable Fall-Through Output

The block is a synchronous FIFO controller that wraps a simple dual-port storage array. It has one write port and one read port of the same width, and both sides run on the same clock. Around the array it manages the write and read pointers and a registered output word. It produces the full and empty flags, almost-full and almost-empty flags with levels set from outside, one-cycle error pulses for rejected accesses, and occupancy counts.

The `fwft_mode` input chooses the output behaviour. In standard mode a read request moves the oldest word into the output register, and the word is there one cycle later. In fall-through mode the controller fetches a word into the output register as soon as one is stored, so the oldest word waits on `rd_data` before any read request. A read request then only consumes that word. `fwft_mode` is meant to be changed only while `rst` is high. Every flag is derived from registered state in the same clock domain, so each flag changes after a fixed number of edges.

Top module: `fwft_fifo_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all state clears. After that edge `empty`=1, `full`=0, both counts are 0 and both error flags are 0.
- R2: In standard mode (`fwft_mode`=0), a read accepted at an edge puts the oldest stored word on `rd_data` right after that edge. Words come out in write order, and `empty` is 1 exactly when the count is 0.
- R3: In standard mode `full` is 1 when DEPTH words are stored. A write request while `full` is 1 is dropped: neither the count nor the stored data changes.
- R4: A read request while `empty` is 1 is refused and raises `rd_err` for the one cycle after that edge. A write request while `full` is 1 raises `wr_err` in the same way. With no further bad request, each flag returns to 0 on the next edge.
- R5: `wr_count` and `rd_count` both give the number of words held, including a word waiting in the output register. An accepted read and an accepted write at the same edge leave the counts unchanged.
- R6: In fall-through mode (`fwft_mode`=1), a word written into an empty FIFO appears on `rd_data` without any read request. `empty` stays 1 after the write edge and falls to 0 after the next edge, together with the word appearing.
- R7: In fall-through mode, a read accepted at an edge puts the next stored word on `rd_data` right after that same edge. When the last word is read, `empty` returns to 1. While no read is requested, the shown word stays on `rd_data`.
- R8: In fall-through mode the FIFO holds DEPTH+1 words: DEPTH in the array and one in the output register. `full` is 1 when the array holds DEPTH words.
- R9: `almost_empty` is 1 when the count is less than or equal to `ae_level`. `almost_full` is 1 when the count is greater than or equal to `af_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| fwft_mode | input | 1 | 1 selects fall-through output, 0 selects standard output |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word register |
| ae_level | input | ADDR_W+1 | Almost-empty threshold |
| af_level | input | ADDR_W+1 | Almost-full threshold |
| full | output | 1 | No room for another write |
| empty | output | 1 | No word available to read |
| almost_full | output | 1 | Count at or above `af_level` |
| almost_empty | output | 1 | Count at or below `ae_level` |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| rd_err | output | 1 | One-cycle pulse after a refused read |
| wr_count | output | ADDR_W+1 | Words held, write-side view |
| rd_count | output | ADDR_W+1 | Words held, read-side view |

## Verification
Short bursts of writes followed by reads in each mode show the difference in output timing. In standard mode the word appears right after the read edge. In fall-through mode it appears one edge after the write, with no read request. Filling the FIFO to the limit and then writing once more separates the two capacities (DEPTH against DEPTH+1). Draining that full FIFO in order then shows that the refused word was never stored. Reads while empty, and a read paired with a write at the same edge, exercise the error pulses and the unchanged count. Stepping the count across the fill range shows exactly where the almost flags switch.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;

  // words held: array contents plus an occupied output register
  function automatic int unsigned fill_level(int unsigned ram_words, logic out_held);
    return ram_words + (out_held ? 32'd1 : 32'd0);
  endfunction

  function automatic logic at_or_below(int unsigned lvl, int unsigned thr);
    return lvl <= thr;
  endfunction

  function automatic logic at_or_above(int unsigned lvl, int unsigned thr);
    return lvl >= thr;
  endfunction

endpackage

// File: rtl/fwft_fifo_ram.sv
module fwft_fifo_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fwft_fifo_ptrs.sv
module fwft_fifo_ptrs #(
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0]  ram_words,
  output logic              ram_full,
  output logic              ram_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      ram_words <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   ram_words <= ram_words + 1'b1;
        2'b01:   ram_words <= ram_words - 1'b1;
        default: ram_words <= ram_words;
      endcase
    end
  end

  assign ram_full  = (ram_words == DEPTH_C);
  assign ram_empty = (ram_words == '0);

  // R3: the write side never pushes into a full array
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !ram_full);
  // R2: the read side never pops an empty array
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !ram_empty);
  // R5: a lone push raises the stored level by exactly one
  a_r5_push_level: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> ram_words == $past(ram_words) + 1'b1);
endmodule

// File: rtl/fwft_fifo_outstage.sv
module fwft_fifo_outstage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwft,
  input  logic              rd_en,
  input  logic              ram_empty,
  input  logic [DATA_W-1:0] ram_q,
  output logic              rd_ok,
  output logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    if (fwft) begin
      rd_ok = rd_en && out_valid;
      pop   = !ram_empty && (!out_valid || rd_ok);
    end else begin
      rd_ok = rd_en && !ram_empty;
      pop   = rd_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (pop) rd_data <= ram_q;
      if (!fwft)      out_valid <= 1'b0;
      else if (pop)   out_valid <= 1'b1;
      else if (rd_ok) out_valid <= 1'b0;
    end
  end

  // R7: with no read request, the shown word stays in place
  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (fwft && out_valid && !rd_en) |=> (out_valid && $stable(rd_data)));
  // R6: a stored word is fetched whenever the output register is free
  a_r6_prefetch: assert property (@(posedge clk) disable iff (rst)
    (fwft && !out_valid && !ram_empty) |=> out_valid);
endmodule

// File: rtl/fwft_fifo_ctrl.sv
module fwft_fifo_ctrl
  import fwft_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  ae_level,
  input  logic [CNT_W-1:0]  af_level,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty,
  output logic              wr_err,
  output logic              rd_err,
  output logic [CNT_W-1:0]  wr_count,
  output logic [CNT_W-1:0]  rd_count
);
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  ram_words, level;
  logic [DATA_W-1:0] ram_q;
  logic ram_full, ram_empty, out_valid;
  logic push, pop, rd_ok, wr_reject, rd_reject;

  assign push      = wr_en && !ram_full;
  assign wr_reject = wr_en && ram_full;

  fwft_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ram_words(ram_words),
    .ram_full(ram_full), .ram_empty(ram_empty)
  );

  fwft_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(ram_q)
  );

  fwft_fifo_outstage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .fwft(fwft_mode), .rd_en(rd_en),
    .ram_empty(ram_empty), .ram_q(ram_q), .rd_ok(rd_ok), .pop(pop),
    .out_valid(out_valid), .rd_data(rd_data)
  );

  assign rd_reject = rd_en && !rd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err <= 1'b0;
      rd_err <= 1'b0;
    end else begin
      wr_err <= wr_reject;
      rd_err <= rd_reject;
    end
  end

  assign level        = CNT_W'(fill_level(32'(ram_words), out_valid));
  assign wr_count     = level;
  assign rd_count     = level;
  assign full         = ram_full;
  assign empty        = fwft_mode ? !out_valid : ram_empty;
  assign almost_empty = at_or_below(32'(level), 32'(ae_level));
  assign almost_full  = at_or_above(32'(level), 32'(af_level));

  // R4: a read on an empty FIFO is flagged on the next cycle
  a_r4_rd_err: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> rd_err);
  // R4: a write on a full FIFO is flagged on the next cycle
  a_r4_wr_err: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> wr_err);
  // R3: a refused write with no read leaves the count alone
  a_r3_reject_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> wr_count == $past(wr_count));
  // R5: an accepted read paired with an accepted write keeps the count
  a_r5_balanced: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full && rd_en && !empty) |=> rd_count == $past(rd_count));
endmodule

// File: tb/fwft_fifo_ctrl_tb.sv
module fwft_fifo_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rst = 1, fwft_mode = 0, wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [CNT_W-1:0] ae_level = 5'd2, af_level = 5'd14, wr_count, rd_count;
  logic full, empty, almost_full, almost_empty, wr_err, rd_err;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwft_fifo_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .fwft_mode(fwft_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ae_level(ae_level), .af_level(af_level),
    .full(full), .empty(empty), .almost_full(almost_full), .almost_empty(almost_empty),
    .wr_err(wr_err), .rd_err(rd_err), .wr_count(wr_count), .rd_count(rd_count)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [DATA_W-1:0] wd, input logic re);
    wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk); #2;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic do_reset(input logic mode);
    rst = 1; fwft_mode = mode;
    @(posedge clk); @(posedge clk); #2;
    rst = 0;
  endtask

  task automatic t_reset;
    do_reset(0);
    chk("R1", "empty", 32'(empty), 1);
    chk("R1", "full", 32'(full), 0);
    chk("R1", "wr_count", 32'(wr_count), 0);
    chk("R1", "rd_count", 32'(rd_count), 0);
    chk("R1", "errs", 32'({wr_err, rd_err}), 0);
  endtask

  task automatic t_std_basic;
    do_reset(0);
    step(1, 16'hA001, 0);
    chk("R2", "empty after one write", 32'(empty), 0);
    step(1, 16'hA002, 0);
    step(1, 16'hA003, 0);
    chk("R5", "count 3", 32'(wr_count), 3);
    step(1, 16'hA004, 1);
    chk("R2", "first word", 32'(rd_data), 16'hA001);
    chk("R5", "read+write keeps count", 32'(rd_count), 3);
    for (int i = 2; i <= 4; i++) begin
      step(0, '0, 1);
      chk("R2", "ordered word", 32'(rd_data), 32'(16'hA000 + i));
    end
    chk("R2", "empty after drain", 32'(empty), 1);
  endtask

  task automatic t_std_errors;
    logic [DATA_W-1:0] held;
    held = rd_data;
    step(0, '0, 1);
    chk("R4", "rd_err pulse", 32'(rd_err), 1);
    chk("R4", "data untouched", 32'(rd_data), 32'(held));
    chk("R4", "count stays 0", 32'(rd_count), 0);
    step(0, '0, 0);
    chk("R4", "rd_err clears", 32'(rd_err), 0);
  endtask

  task automatic t_std_fill;
    do_reset(0);
    ae_level = 5'd2; af_level = 5'd14;
    for (int k = 1; k <= DEPTH; k++) begin
      step(1, 16'(16'h0100 + k), 0);
      chk("R9", "almost_empty", 32'(almost_empty), 32'(k <= 2));
      chk("R9", "almost_full", 32'(almost_full), 32'(k >= 14));
    end
    chk("R3", "full at DEPTH", 32'(full), 1);
    step(1, 16'hDEAD, 0);
    chk("R4", "wr_err pulse", 32'(wr_err), 1);
    chk("R3", "count after refused write", 32'(wr_count), DEPTH);
    step(0, '0, 0);
    chk("R4", "wr_err clears", 32'(wr_err), 0);
    for (int k = 1; k <= DEPTH; k++) begin
      step(0, '0, 1);
      chk("R3", "stored data intact", 32'(rd_data), 32'(16'h0100 + k));
    end
    chk("R3", "empty after drain", 32'(empty), 1);
  endtask

  task automatic t_fwft_basic;
    do_reset(1);
    step(1, 16'hB0B1, 0);
    chk("R6", "still empty after write edge", 32'(empty), 1);
    chk("R5", "count includes array word", 32'(wr_count), 1);
    step(0, '0, 0);
    chk("R6", "not empty next edge", 32'(empty), 0);
    chk("R6", "word shown without read", 32'(rd_data), 16'hB0B1);
    step(1, 16'hB0B2, 0);
    step(1, 16'hB0B3, 0);
    chk("R7", "held word stable", 32'(rd_data), 16'hB0B1);
    chk("R5", "count 3", 32'(rd_count), 3);
    step(0, '0, 1);
    chk("R7", "next word", 32'(rd_data), 16'hB0B2);
    step(0, '0, 1);
    chk("R7", "third word", 32'(rd_data), 16'hB0B3);
    chk("R7", "not empty yet", 32'(empty), 0);
    step(0, '0, 1);
    chk("R7", "empty after last", 32'(empty), 1);
    chk("R5", "count 0", 32'(rd_count), 0);
    step(0, '0, 1);
    chk("R4", "fwft rd_err", 32'(rd_err), 1);
  endtask

  task automatic t_fwft_fill;
    do_reset(1);
    af_level = 5'd17;
    for (int k = 1; k <= DEPTH + 1; k++) begin
      step(1, 16'(16'h0C00 + k), 0);
      chk("R8", "level tracks writes", 32'(wr_count), k);
    end
    chk("R8", "full at DEPTH+1", 32'(full), 1);
    chk("R9", "almost_full at 17", 32'(almost_full), 1);
    step(1, 16'hBEEF, 0);
    chk("R4", "wr_err in fwft", 32'(wr_err), 1);
    chk("R8", "count unchanged", 32'(wr_count), DEPTH + 1);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      chk("R8", "drain order", 32'(rd_data), 32'(16'h0C00 + k));
      step(0, '0, 1);
    end
    chk("R8", "empty after drain", 32'(empty), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_std_basic();
    t_std_errors();
    t_std_fill();
    t_fwft_basic();
    t_fwft_fill();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule